// File: doc/BRIEF.md
# Quad Power Sequencing Controller

This block brings up four downstream supplies in a fixed cascade: stage A first, then B, then C, then D. It does so only while the monitored input supply sits inside an undervoltage/overvoltage window. The analog side is reduced to digital comparator flags. Each sense has a high-threshold flag and a low-threshold flag, and a separate lockout-ok flag reports that the internal supply is valid. Every flag is asynchronous to the block clock and passes through a two-flop synchronizer.

Once the window is qualified, a power-on wait of a programmable number of clock cycles runs, and then stage A is released. Each later stage is released after its own delay. That delay is 255 full periods of a per-stage timebase, and each period is two programmable half-periods. Leaving the window drops every stage in the same cycle and returns the sequencer to idle. A fresh sequence, starting again with the power-on wait, begins as soon as the window is regained.

The configuration values are captured only while the sequencer is idle. A status state code and a sticky fault flag report progress and window losses. All pins are plain control and status levels, so no stream handshake applies to this block.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, and for as long as lockout_ok_i stays low, state_o is 0, fault_o is 0 and en_pull_low_o is 4'b1111.
- R2: UV hysteresis. The window can only be entered while uv_hi_i is 1. Once entered, uv_hi_i returning to 0 has no effect as long as uv_lo_i stays 1, and uv_lo_i at 0 loses the window.
- R3: OV hysteresis. ov_hi_i at 1 loses the window. The window stays lost after ov_hi_i returns to 0 while ov_lo_i stays 1, and it is regained only once ov_lo_i is 0.
- R4: A flag change that qualifies the window, driven just after clock edge n, puts the sequencer in the power-on wait after edge n+4. Stage A is released (en_pull_low_o[0] goes to 0) after edge n+4+cfg_por_i. The wait lasts one cycle when cfg_por_i is 0.
- R5: Stage B is released exactly 510*cfg_half_b_i cycles after A. C is released 510*cfg_half_c_i cycles after B, and D is released 510*cfg_half_d_i cycles after C. This is 255 periods of two half-periods each, and a half-period of 0 counts as 1.
- R6: A flag change that loses the window, driven just after edge n, sets en_pull_low_o to 4'b1111 after edge n+3, which is the same cycle the internal window drops. state_o reads 0 after edge n+4.
- R7: When the window is regained after a loss, the sequence restarts from the power-on wait with the full delays of R4 and R5.
- R8: cfg_por_i and cfg_half_*_i are captured only while state_o is 0. Changes made during a sequence do not alter its timing.
- R9: state_o encoding: 0 idle, 1 power-on wait, 2 waiting for B, 3 waiting for C, 4 waiting for D, 5 all released. Apart from a return to 0, it only ever advances by one.
- R10: fault_o sets on the cycle after every window loss and stays set until fault_clr_i is 1 for a cycle. A new window loss in that same cycle wins over the clear.
- R11: en_pull_low_o bit 0 is stage A through bit 3 stage D, and a 1 means driven low (inactive). Only the patterns 1111, 1110, 1100, 1000 and 0000 can appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| lockout_ok_i | input | 1 | Internal supply lockout satisfied (asynchronous) |
| uv_hi_i | input | 1 | UV sense above its high threshold (asynchronous) |
| uv_lo_i | input | 1 | UV sense above its low threshold (asynchronous) |
| ov_hi_i | input | 1 | OV sense above its high threshold (asynchronous) |
| ov_lo_i | input | 1 | OV sense above its low threshold (asynchronous) |
| cfg_por_i | input | POR_W | Power-on wait in clock cycles |
| cfg_half_b_i | input | DIV_W | Half-period of stage B timebase in clock cycles |
| cfg_half_c_i | input | DIV_W | Half-period of stage C timebase in clock cycles |
| cfg_half_d_i | input | DIV_W | Half-period of stage D timebase in clock cycles |
| fault_clr_i | input | 1 | Write-one clear of the sticky fault flag |
| en_pull_low_o | output | 4 | Per-stage drive-low control, 1 = inactive |
| state_o | output | 3 | Sequencer state code |
| fault_o | output | 1 | Sticky window-loss flag |

## Verification
The assertions assume consistent comparator flags. A high-threshold flag is never 1 while its matching low-threshold flag is 0, since a sense level cannot exceed its upper threshold and not its lower one. They also assume fault_clr_i is a plain level that the bench drives as a one-cycle pulse. The stimulus changes flags only at falling clock edges and always moves each high/low pair in a consistent order. It holds each new level for many cycles, so the synchronizers never see a pulse shorter than a clock.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_STAGES = 4;
  localparam int STATE_W    = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 3'd0,
    ST_POR    = 3'd1,
    ST_DLY_B  = 3'd2,
    ST_DLY_C  = 3'd3,
    ST_DLY_D  = 3'd4,
    ST_ALL_UP = 3'd5
  } seq_state_e;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end

endmodule

// File: rtl/pwr_seq_window.sv
module pwr_seq_window (
  input  logic clk,
  input  logic rst,
  input  logic lock_ok_s,
  input  logic uv_hi_s,
  input  logic uv_lo_s,
  input  logic ov_hi_s,
  input  logic ov_lo_s,
  output logic win_o
);

  logic uv_ok_q;
  logic ov_flt_q;

  // UV: drop below low threshold wins; entry needs the high threshold.
  always_ff @(posedge clk) begin
    if (rst || !lock_ok_s) begin
      uv_ok_q <= 1'b0;
    end else if (!uv_lo_s) begin
      uv_ok_q <= 1'b0;
    end else if (uv_hi_s) begin
      uv_ok_q <= 1'b1;
    end
  end

  // OV: crossing the high threshold wins; clearing needs the low threshold.
  always_ff @(posedge clk) begin
    if (rst || !lock_ok_s) begin
      ov_flt_q <= 1'b0;
    end else if (ov_hi_s) begin
      ov_flt_q <= 1'b1;
    end else if (!ov_lo_s) begin
      ov_flt_q <= 1'b0;
    end
  end

  assign win_o = lock_ok_s && uv_ok_q && !ov_flt_q;

endmodule

// File: rtl/pwr_seq_timebase.sv
module pwr_seq_timebase #(
  parameter int DIV_W   = 12,
  parameter int PER_W   = 8,
  parameter int PERIODS = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             done_o
);

  localparam logic [PER_W-1:0] LAST_PER = PER_W'(PERIODS - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] half_eff;
  logic             phase_q;   // 0 = charge half, 1 = discharge half
  logic [PER_W-1:0] per_q;
  logic             half_end;

  always_comb begin
    half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  end

  assign half_end = (div_q == half_eff - DIV_W'(1));
  assign done_o   = run_i && half_end && phase_q && (per_q == LAST_PER);

  always_ff @(posedge clk) begin
    if (rst || !run_i || done_o) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      per_q   <= '0;
    end else if (half_end) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
      if (phase_q) begin
        per_q <= per_q + PER_W'(1);
      end
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int POR_W   = 16,
  parameter int DIV_W   = 12,
  parameter int PER_W   = 8,
  parameter int PERIODS = 255
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lockout_ok_i,
  input  logic                  uv_hi_i,
  input  logic                  uv_lo_i,
  input  logic                  ov_hi_i,
  input  logic                  ov_lo_i,
  input  logic [POR_W-1:0]      cfg_por_i,
  input  logic [DIV_W-1:0]      cfg_half_b_i,
  input  logic [DIV_W-1:0]      cfg_half_c_i,
  input  logic [DIV_W-1:0]      cfg_half_d_i,
  input  logic                  fault_clr_i,
  output logic [NUM_STAGES-1:0] en_pull_low_o,
  output logic [STATE_W-1:0]    state_o,
  output logic                  fault_o
);

  localparam int POR_CW = POR_W + 1;
  localparam int N_DLY  = NUM_STAGES - 1;

  // ---------------- input synchronization ----------------
  logic [4:0] flags_s;
  logic       lock_s, uv_hi_s, uv_lo_s, ov_hi_s, ov_lo_s;

  pwr_seq_sync #(.W(5)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({ov_lo_i, ov_hi_i, uv_lo_i, uv_hi_i, lockout_ok_i}),
    .sync_o  (flags_s)
  );

  assign {ov_lo_s, ov_hi_s, uv_lo_s, uv_hi_s, lock_s} = flags_s;

  // ---------------- window qualification ----------------
  logic win;

  pwr_seq_window u_window (
    .clk       (clk),
    .rst       (rst),
    .lock_ok_s (lock_s),
    .uv_hi_s   (uv_hi_s),
    .uv_lo_s   (uv_lo_s),
    .ov_hi_s   (ov_hi_s),
    .ov_lo_s   (ov_lo_s),
    .win_o     (win)
  );

  // ---------------- configuration snapshot ----------------
  seq_state_e       st_q, st_d;
  logic [POR_W-1:0] por_q;
  logic [DIV_W-1:0] half_q [N_DLY];

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q <= '0;
      for (int i = 0; i < N_DLY; i++) half_q[i] <= '0;
    end else if (st_q == ST_IDLE) begin
      por_q     <= cfg_por_i;
      half_q[0] <= cfg_half_b_i;
      half_q[1] <= cfg_half_c_i;
      half_q[2] <= cfg_half_d_i;
    end
  end

  // ---------------- power-on wait counter ----------------
  logic [POR_W-1:0] por_cnt_q;
  logic             por_done;

  always_ff @(posedge clk) begin
    if (rst || !(st_q == ST_POR && win)) begin
      por_cnt_q <= '0;
    end else begin
      por_cnt_q <= por_cnt_q + POR_W'(1);
    end
  end

  assign por_done = (st_q == ST_POR) &&
                    (({1'b0, por_cnt_q} + POR_CW'(1)) >= {1'b0, por_q});

  // ---------------- shared inter-stage timebase ----------------
  logic             tb_run;
  logic             tb_done;
  logic [DIV_W-1:0] tb_half;

  always_comb begin
    tb_run  = 1'b0;
    tb_half = half_q[0];
    unique case (st_q)
      ST_DLY_B: begin tb_run = win; tb_half = half_q[0]; end
      ST_DLY_C: begin tb_run = win; tb_half = half_q[1]; end
      ST_DLY_D: begin tb_run = win; tb_half = half_q[2]; end
      default:  ;
    endcase
  end

  pwr_seq_timebase #(
    .DIV_W   (DIV_W),
    .PER_W   (PER_W),
    .PERIODS (PERIODS)
  ) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .run_i  (tb_run),
    .half_i (tb_half),
    .done_o (tb_done)
  );

  // ---------------- sequencer ----------------
  always_comb begin
    st_d = st_q;
    if (!win) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:   st_d = ST_POR;
        ST_POR:    if (por_done) st_d = ST_DLY_B;
        ST_DLY_B:  if (tb_done)  st_d = ST_DLY_C;
        ST_DLY_C:  if (tb_done)  st_d = ST_DLY_D;
        ST_DLY_D:  if (tb_done)  st_d = ST_ALL_UP;
        ST_ALL_UP: st_d = ST_ALL_UP;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign state_o = st_q;

  // ---------------- enable outputs ----------------
  // Stage i counts as up once the sequencer has moved past its wait.
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_en
    assign en_pull_low_o[i] = ~(win && (st_q >= STATE_W'(i + 2)));
  end

  // ---------------- sticky fault ----------------
  logic win_d_q;
  logic fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_d_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      win_d_q <= win;
      if (win_d_q && !win)  fault_q <= 1'b1;
      else if (fault_clr_i) fault_q <= 1'b0;
    end
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  win,
  input logic [NUM_STAGES-1:0] en,
  input logic [STATE_W-1:0]    state,
  input logic                  fault,
  input logic                  fault_clr
);

  // R6: outside the window every stage is driven low in that cycle
  p_drop_same_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    !win |-> en == 4'b1111);

  // R1: idle never releases a stage
  p_idle_held_r1: assert property (@(posedge clk) disable iff (rst)
    state == 3'd0 |-> en == 4'b1111);

  // R11: stages are only ever released in cascade order
  p_release_order_r11: assert property (@(posedge clk) disable iff (rst)
    en inside {4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000});

  // R9: valid codes only
  p_state_range_r9: assert property (@(posedge clk) disable iff (rst)
    state <= 3'd5);

  // R9: state advances by one or falls back to idle
  p_state_step_r9: assert property (@(posedge clk) disable iff (rst)
    state != $past(state) |-> (state == 3'd0 || state == $past(state) + 3'd1));

  // R10: a window loss sets the sticky flag
  p_fault_set_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(win) |=> fault);

  // R10: write-one clear when no new loss competes
  p_fault_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (fault_clr && !$fell(win)) |=> !fault);

endmodule

bind pwr_seq_ctrl pwr_seq_chk u_pwr_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .win       (win),
  .en        (en_pull_low_o),
  .state     (state_o),
  .fault     (fault_o),
  .fault_clr (fault_clr_i)
);

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

  localparam int POR_W = 16;
  localparam int DIV_W = 12;
  localparam int WDOG  = 60000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             lockout_ok_i, uv_hi_i, uv_lo_i, ov_hi_i, ov_lo_i;
  logic [POR_W-1:0] cfg_por_i;
  logic [DIV_W-1:0] cfg_half_b_i, cfg_half_c_i, cfg_half_d_i;
  logic             fault_clr_i;
  logic [3:0]       en_pull_low_o;
  logic [2:0]       state_o;
  logic             fault_o;

  always #10 clk = ~clk;  // 50 MHz

  pwr_seq_ctrl #(.POR_W(POR_W), .DIV_W(DIV_W)) i_pwr_seq_ctrl (
    .clk           (clk),
    .rst           (rst),
    .lockout_ok_i  (lockout_ok_i),
    .uv_hi_i       (uv_hi_i),
    .uv_lo_i       (uv_lo_i),
    .ov_hi_i       (ov_hi_i),
    .ov_lo_i       (ov_lo_i),
    .cfg_por_i     (cfg_por_i),
    .cfg_half_b_i  (cfg_half_b_i),
    .cfg_half_c_i  (cfg_half_c_i),
    .cfg_half_d_i  (cfg_half_d_i),
    .fault_clr_i   (fault_clr_i),
    .en_pull_low_o (en_pull_low_o),
    .state_o       (state_o),
    .fault_o       (fault_o)
  );

  int cyc = 0;
  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         at;
    logic [3:0] val;
    string      req;
  } exp_t;

  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int at, input logic [3:0] val, input string req);
    exp_t e;
    e.at = at; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  // Expected enable changes of a sequence whose qualifying flag change
  // was driven at negedge count c0.
  task automatic expect_seq(input int c0, input int por, input int hb,
                            input int hc, input int hd, input int n,
                            input string tag_a, input string tag_rest);
    int t;
    t = c0 + 4 + ((por == 0) ? 1 : por);
    push(t, 4'b1110, tag_a);
    if (n > 1) begin t += 510 * hb; push(t, 4'b1100, tag_rest); end
    if (n > 2) begin t += 510 * hc; push(t, 4'b1000, tag_rest); end
    if (n > 3) begin t += 510 * hd; push(t, 4'b0000, tag_rest); end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: pops expected enable changes as the design produces them.
  logic [3:0] en_prev = 4'b1111;
  always @(negedge clk) begin
    exp_t e;
    if (!rst && en_pull_low_o !== en_prev) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R11 unexpected enable change: actual %b at cycle %0d, expected %b",
                 en_pull_low_o, cyc, en_prev);
      end else begin
        e = exp_q.pop_front();
        if (en_pull_low_o !== e.val || cyc != e.at) begin
          n_err++;
          $display("FAIL %s enable change: actual %b at cycle %0d, expected %b at cycle %0d",
                   e.req, en_pull_low_o, cyc, e.val, e.at);
        end
      end
      en_prev = en_pull_low_o;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (!done && cyc > WDOG) begin
      n_err++;
      $display("FAIL R5 watchdog expired: actual cycle %0d expected below %0d", cyc, WDOG);
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int c;
    lockout_ok_i = 1'b0;
    uv_hi_i = 1'b1; uv_lo_i = 1'b1;
    ov_hi_i = 1'b0; ov_lo_i = 1'b0;
    cfg_por_i = 16'd20;
    cfg_half_b_i = 12'd1; cfg_half_c_i = 12'd2; cfg_half_d_i = 12'd1;
    fault_clr_i = 1'b0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R1", "state in reset", state_o, 0);
    chk(en_pull_low_o == 4'b1111, "R1", "enables in reset", en_pull_low_o, 15);
    chk(fault_o == 1'b0, "R1", "fault in reset", fault_o, 0);
    rst = 1'b0;

    // R1: lockout holds everything off even with a good window
    repeat (40) @(negedge clk);
    chk(state_o == 3'd0, "R1", "state under lockout", state_o, 0);
    chk(en_pull_low_o == 4'b1111, "R1", "enables under lockout", en_pull_low_o, 15);

    // R4/R5/R9: first full sequence
    c = cyc;
    lockout_ok_i = 1'b1;
    expect_seq(c, 20, 1, 2, 1, 4, "R4", "R5");
    wait_to(c + 3);
    chk(state_o == 3'd0, "R4", "state before POR", state_o, 0);
    wait_to(c + 4);
    chk(state_o == 3'd1, "R9", "state POR wait", state_o, 1);
    wait_to(c + 24);
    chk(state_o == 3'd2, "R9", "state waiting B", state_o, 2);
    wait_to(c + 24 + 520);
    chk(state_o == 3'd3, "R9", "state waiting C", state_o, 3);
    wait_to(c + 2064 + 5);
    chk(state_o == 3'd5, "R9", "state all up", state_o, 5);

    // R6/R10: UV loss after completion
    c = cyc;
    uv_hi_i = 1'b0; uv_lo_i = 1'b0;
    push(c + 3, 4'b1111, "R6");
    wait_to(c + 3);
    chk(fault_o == 1'b0, "R10", "fault before set", fault_o, 0);
    wait_to(c + 4);
    chk(state_o == 3'd0, "R6", "state after loss", state_o, 0);
    chk(fault_o == 1'b1, "R10", "fault after loss", fault_o, 1);

    // R2: inside hysteresis band, no entry without the high flag
    uv_lo_i = 1'b1;
    repeat (60) @(negedge clk);
    chk(state_o == 3'd0, "R2", "state without uv high", state_o, 0);
    chk(en_pull_low_o == 4'b1111, "R2", "enables without uv high", en_pull_low_o, 15);

    // R10: write-one clear
    chk(fault_o == 1'b1, "R10", "fault sticky", fault_o, 1);
    fault_clr_i = 1'b1;
    @(negedge clk);
    fault_clr_i = 1'b0;
    chk(fault_o == 1'b0, "R10", "fault cleared", fault_o, 0);

    // R2/R8: enter on uv high, then drop uv high (held by hysteresis);
    // config changes mid-sequence must not alter timing.
    c = cyc;
    uv_hi_i = 1'b1;
    expect_seq(c, 20, 1, 2, 1, 4, "R2", "R8");
    wait_to(c + 5);
    uv_hi_i = 1'b0;
    wait_to(c + 10);
    cfg_por_i = 16'd200;
    cfg_half_b_i = 12'd3;
    wait_to(c + 2064 + 5);
    chk(state_o == 3'd5, "R8", "state all up with old config", state_o, 5);
    cfg_por_i = 16'd20;
    cfg_half_b_i = 12'd1;

    // R3: OV loss, band hold, then recovery
    c = cyc;
    ov_lo_i = 1'b1; ov_hi_i = 1'b1;
    push(c + 3, 4'b1111, "R3");
    wait_to(c + 20);
    ov_hi_i = 1'b0;
    repeat (100) @(negedge clk);
    chk(state_o == 3'd0, "R3", "state in ov band", state_o, 0);
    chk(en_pull_low_o == 4'b1111, "R3", "enables in ov band", en_pull_low_o, 15);
    c = cyc;
    ov_lo_i = 1'b0;
    expect_seq(c, 20, 1, 2, 1, 2, "R3", "R5");

    // R6: loss in the middle of the cascade
    wait_to(c + 24 + 510 + 100);
    chk(state_o == 3'd3, "R9", "state waiting C", state_o, 3);
    c = cyc;
    uv_hi_i = 1'b0; uv_lo_i = 1'b0;
    push(c + 3, 4'b1111, "R6");
    wait_to(c + 4);
    chk(state_o == 3'd0, "R6", "state after mid-sequence loss", state_o, 0);

    // R7: fresh restart with full timing
    repeat (20) @(negedge clk);
    c = cyc;
    uv_lo_i = 1'b1; uv_hi_i = 1'b1;
    expect_seq(c, 20, 1, 2, 1, 4, "R7", "R7");
    wait_to(c + 4);
    chk(state_o == 3'd1, "R7", "restart enters POR wait", state_o, 1);
    wait_to(c + 2064 + 5);
    chk(state_o == 3'd5, "R7", "restart completes", state_o, 5);
    chk(en_pull_low_o == 4'b0000, "R11", "all released", en_pull_low_o, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "pending enable events", exp_q.size(), 0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule